// File: doc/BRIEF.md
# Segmented Receive Sample Ring Read Controller

This block runs the read side of a receive sample ring whose storage is split over three places: a fixed main area of eight slots at a parameter base address, and two extra regions whose base addresses and lengths are programmed at run time. A consumer asks for the next sample with a one-cycle request. The block answers with either the 16-bit physical address of that sample or an "empty" indication. It owns the logical read pointer and keeps a local copy of the producer's write pointer. When the ring looks empty it refreshes that copy once before answering.

The configuration is checked when the ring is switched on. A configuration that fails the check drops the block into a fallback mode, in which the ring is only the main area used as two halves of `PKT` slots. In that mode the producer's position is a single flag bit, and each interrupt moves the reader to the half that the producer is not writing. A zero-valued sample seen by the consumer ends the current burst early. Base and length registers can be written only while the ring is off.

Top module: `sample_ring_reader`

## Requirements
- R1: After reset, `rsp_valid`, `rsp_empty`, `ext_active`, `cfg_fault` and `range_err` are all 0.
- R2: Logical offsets 0 to 7 read from `MAIN_BASE` plus the offset.
- R3: In segmented mode, offsets 8 to 8+len1-1 read from base1 plus (offset-8), and the following len2 offsets read from base2 plus (offset-8-len1).
- R4: After each address is issued, the read pointer increments. It returns to 0 once the incremented value reaches or passes the ring length: len1+len2+8 in segmented mode, 2*PKT in fallback mode.
- R5: When the read pointer equals the write pointer copy, a request reloads the copy from the producer. Two cycles after the request, the block issues an address if the pointers now differ, or raises `rsp_empty` for one cycle if they do not.
- R6: On the rising edge of `ring_en` with register 4 bit 0 set, segmented mode is entered only if these checks pass: 16 <= len1+len2+8 <= 64, both bases lie in 0xEC00..0xFBFC inclusive, and the starting write pointer is at most the ring length. Otherwise `cfg_fault` is set and fallback mode is used.
- R7: In fallback mode, the producer position is 0 when `legacy_wflag` is 1 and PKT when it is 0. An `irq` pulse reloads the copy and sets the read pointer to the other half (PKT when the position is 0, otherwise 0).
- R8: A `zero_seen` pulse in fallback mode sets the read pointer to the write pointer copy, so the next request reports empty. In segmented mode it has no effect.
- R9: An offset beyond all regions returns address 0 with `rsp_valid` and sets `range_err`, which stays set until reset.
- R10: Configuration writes (register 0 base1, 1 len1, 2 base2, 3 len2, 4 bit 0 segmented request) take effect only while `ring_en` is 0.
- R11: A request with the pointers unequal is answered one cycle later. `rsp_valid` and `rsp_empty` are never high together, and no response appears while `ring_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_en | input | 1 | Ring on; its rising edge validates and starts |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register index |
| cfg_wdata | input | 16 | Configuration write data |
| wptr_hw | input | 8 | Producer write pointer (segmented mode) |
| legacy_wflag | input | 1 | Producer half flag (fallback mode) |
| irq | input | 1 | Receive interrupt pulse |
| zero_seen | input | 1 | Consumer saw a zero-valued sample |
| req | input | 1 | Request next sample address |
| rsp_valid | output | 1 | `rsp_addr` holds a sample address |
| rsp_empty | output | 1 | No sample available |
| rsp_addr | output | 16 | Physical sample address |
| ext_active | output | 1 | Segmented mode in use |
| cfg_fault | output | 1 | Last start failed validation |
| range_err | output | 1 | Sticky out-of-region read |

## Verification
A request made while the pointers differ is answered on the edge that samples it, so the bench expects the response one cycle later. A request that finds the ring empty costs one extra edge for the reload, so the bench expects that response two cycles later. The mode and fault flags change on the edge that sees `ring_en` rise. The driver stamps each expected response with its due cycle. The monitor checks the cycle, the kind and the address, and it flags any response that no item predicts.

// File: rtl/srr_pkg.sv
package srr_pkg;
  typedef enum logic [1:0] {RD_OFF, RD_RUN, RD_REFRESH} rd_state_t;
  localparam int CFG_AW      = 3;
  localparam int REG_BASE1   = 0;
  localparam int REG_LEN1    = 1;
  localparam int REG_BASE2   = 2;
  localparam int REG_LEN2    = 3;
  localparam int REG_MODE    = 4;
endpackage

// File: rtl/srr_cfg.sv
module srr_cfg #(
  parameter int AW         = 16,
  parameter int PW         = 8,
  parameter int LENW       = 8,
  parameter int MAIN_SLOTS = 8,
  parameter int PKT        = 4,
  parameter int MIN_TOTAL  = 16,
  parameter int MAX_TOTAL  = 64,
  parameter logic [15:0] BASE_LO = 16'hEC00,
  parameter logic [15:0] BASE_HI = 16'hFBFC,
  localparam int TW = LENW + 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ring_en,
  input  logic                      en_rise,
  input  logic                      cfg_we,
  input  logic [srr_pkg::CFG_AW-1:0] cfg_addr,
  input  logic [AW-1:0]             cfg_wdata,
  input  logic [PW-1:0]             start_wptr,
  output logic [AW-1:0]             base1,
  output logic [LENW-1:0]           len1,
  output logic [AW-1:0]             base2,
  output logic [LENW-1:0]           len2,
  output logic                      start_ext,
  output logic                      ext_active,
  output logic                      cfg_fault,
  output logic [TW-1:0]             ring_len
);
  import srr_pkg::*;

  localparam logic [TW-1:0] SLOTS_T = TW'(MAIN_SLOTS);
  localparam logic [TW-1:0] MIN_T   = TW'(MIN_TOTAL);
  localparam logic [TW-1:0] MAX_T   = TW'(MAX_TOTAL);
  localparam logic [TW-1:0] HALF2_T = TW'(2 * PKT);
  localparam logic [AW-1:0] LO_A    = AW'(BASE_LO);
  localparam logic [AW-1:0] HI_A    = AW'(BASE_HI);

  logic          want_ext;
  logic [TW-1:0] total;
  logic          len_ok, b1_ok, b2_ok, ptr_ok, cfg_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      base1    <= '0;
      len1     <= '0;
      base2    <= '0;
      len2     <= '0;
      want_ext <= 1'b0;
    end else if (cfg_we && !ring_en) begin
      case (int'(cfg_addr))
        REG_BASE1: base1    <= cfg_wdata;
        REG_LEN1:  len1     <= cfg_wdata[LENW-1:0];
        REG_BASE2: base2    <= cfg_wdata;
        REG_LEN2:  len2     <= cfg_wdata[LENW-1:0];
        REG_MODE:  want_ext <= cfg_wdata[0];
        default: ;
      endcase
    end
  end

  always_comb begin
    total  = TW'(len1) + TW'(len2) + SLOTS_T;
    len_ok = (total >= MIN_T) && (total <= MAX_T);
    b1_ok  = (base1 >= LO_A) && (base1 <= HI_A);
    b2_ok  = (base2 >= LO_A) && (base2 <= HI_A);
    ptr_ok = TW'(start_wptr) <= total;
    cfg_ok = len_ok && b1_ok && b2_ok && ptr_ok;
    start_ext = want_ext && cfg_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ext_active <= 1'b0;
      cfg_fault  <= 1'b0;
    end else if (en_rise) begin
      ext_active <= start_ext;
      cfg_fault  <= want_ext && !cfg_ok;
    end
  end

  assign ring_len = ext_active ? total : HALF2_T;

  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (rst)
    $past(ring_en) |-> ($stable(base1) && $stable(len1) && $stable(base2) && $stable(len2)));

  a_r6_fault_is_fallback: assert property (@(posedge clk) disable iff (rst)
    cfg_fault |-> !ext_active);
endmodule

// File: rtl/srr_addr_map.sv
module srr_addr_map #(
  parameter int AW         = 16,
  parameter int PW         = 8,
  parameter int LENW       = 8,
  parameter logic [15:0] MAIN_BASE = 16'hF8A0,
  parameter int MAIN_SLOTS = 8,
  parameter int PKT        = 4,
  localparam int TW = LENW + 2
) (
  input  logic            ext,
  input  logic [PW-1:0]   off,
  input  logic [AW-1:0]   base1,
  input  logic [LENW-1:0] len1,
  input  logic [AW-1:0]   base2,
  input  logic [LENW-1:0] len2,
  output logic [AW-1:0]   addr,
  output logic            miss
);
  localparam logic [TW-1:0] SLOTS_T = TW'(MAIN_SLOTS);
  localparam logic [TW-1:0] HALF2_T = TW'(2 * PKT);
  localparam logic [AW-1:0] MAIN_A  = AW'(MAIN_BASE);

  logic [TW-1:0] off_t, rel1, rel2, main_lim;

  always_comb begin
    off_t    = TW'(off);
    rel1     = off_t - SLOTS_T;
    rel2     = rel1 - TW'(len1);
    main_lim = ext ? SLOTS_T : HALF2_T;
    addr     = '0;
    miss     = 1'b0;
    if (off_t < main_lim) begin
      addr = MAIN_A + AW'(off_t);
    end else if (!ext) begin
      miss = 1'b1;
    end else if (rel1 < TW'(len1)) begin
      addr = base1 + AW'(rel1);
    end else if (rel2 < TW'(len2)) begin
      addr = base2 + AW'(rel2);
    end else begin
      miss = 1'b1;
    end
  end
endmodule

// File: rtl/srr_ptr_ctrl.sv
module srr_ptr_ctrl #(
  parameter int AW   = 16,
  parameter int PW   = 8,
  parameter int TW   = 10,
  parameter int PKT  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ring_en,
  input  logic          en_rise,
  input  logic          start_ext,
  input  logic          ext_active,
  input  logic [PW-1:0] wptr_hw,
  input  logic          legacy_wflag,
  input  logic          irq,
  input  logic          zero_seen,
  input  logic          req,
  input  logic [TW-1:0] ring_len,
  input  logic [AW-1:0] map_addr,
  input  logic          map_miss,
  output logic [PW-1:0] rptr,
  output logic          rsp_valid,
  output logic          rsp_empty,
  output logic [AW-1:0] rsp_addr,
  output logic          range_err
);
  import srr_pkg::*;

  localparam logic [PW-1:0] PKT_P = PW'(PKT);

  rd_state_t     state;
  logic [PW-1:0] wcopy, wsrc, rnext;
  logic [TW-1:0] inc;
  logic          mode;

  always_comb begin
    mode  = en_rise ? start_ext : ext_active;
    wsrc  = mode ? wptr_hw : (legacy_wflag ? '0 : PKT_P);
    inc   = TW'(rptr) + TW'(1);
    rnext = (inc >= ring_len) ? '0 : PW'(inc);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RD_OFF;
      rptr      <= '0;
      wcopy     <= '0;
      rsp_valid <= 1'b0;
      rsp_empty <= 1'b0;
      rsp_addr  <= '0;
      range_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_empty <= 1'b0;
      if (!ring_en) begin
        state <= RD_OFF;
      end else if (en_rise) begin
        wcopy <= wsrc;
        rptr  <= wsrc;
        state <= RD_RUN;
      end else begin
        case (state)
          RD_RUN: begin
            if (irq) begin
              wcopy <= wsrc;
              if (!ext_active) rptr <= (wsrc == '0) ? PKT_P : '0;
            end else if (zero_seen && !ext_active) begin
              rptr <= wcopy;
            end else if (req) begin
              if (rptr != wcopy) begin
                rsp_valid <= 1'b1;
                rsp_addr  <= map_addr;
                rptr      <= rnext;
                if (map_miss) range_err <= 1'b1;
              end else begin
                wcopy <= wsrc;
                state <= RD_REFRESH;
              end
            end
          end
          RD_REFRESH: begin
            state <= RD_RUN;
            if (rptr != wcopy) begin
              rsp_valid <= 1'b1;
              rsp_addr  <= map_addr;
              rptr      <= rnext;
              if (map_miss) range_err <= 1'b1;
            end else begin
              rsp_empty <= 1'b1;
            end
          end
          default: state <= RD_RUN;
        endcase
      end
    end
  end

  a_r11_one_kind: assert property (@(posedge clk) disable iff (rst)
    !(rsp_valid && rsp_empty));

  a_r5_empty_after_reload: assert property (@(posedge clk) disable iff (rst)
    rsp_empty |-> $past(state == RD_REFRESH));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    $past(range_err) |-> range_err);

  a_r9_miss_addr_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && range_err && !$past(range_err)) |-> (rsp_addr == '0));

  a_r11_silent_when_off: assert property (@(posedge clk) disable iff (rst)
    $past(!ring_en) |-> (!rsp_valid && !rsp_empty));
endmodule

// File: rtl/sample_ring_reader.sv
module sample_ring_reader #(
  parameter int AW         = 16,
  parameter int PW         = 8,
  parameter int LENW       = 8,
  parameter logic [15:0] MAIN_BASE = 16'hF8A0,
  parameter int MAIN_SLOTS = 8,
  parameter int PKT        = 4,
  parameter int MIN_TOTAL  = 16,
  parameter int MAX_TOTAL  = 64,
  parameter logic [15:0] BASE_LO = 16'hEC00,
  parameter logic [15:0] BASE_HI = 16'hFBFC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ring_en,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [AW-1:0] cfg_wdata,
  input  logic [PW-1:0] wptr_hw,
  input  logic          legacy_wflag,
  input  logic          irq,
  input  logic          zero_seen,
  input  logic          req,
  output logic          rsp_valid,
  output logic          rsp_empty,
  output logic [AW-1:0] rsp_addr,
  output logic          ext_active,
  output logic          cfg_fault,
  output logic          range_err
);
  localparam int TW = LENW + 2;

  logic            en_q, en_rise, start_ext, map_miss;
  logic [AW-1:0]   base1, base2, map_addr;
  logic [LENW-1:0] len1, len2;
  logic [TW-1:0]   ring_len;
  logic [PW-1:0]   rptr;

  always_ff @(posedge clk) begin
    if (rst) en_q <= 1'b0;
    else     en_q <= ring_en;
  end
  assign en_rise = ring_en && !en_q;

  srr_cfg #(
    .AW(AW), .PW(PW), .LENW(LENW), .MAIN_SLOTS(MAIN_SLOTS), .PKT(PKT),
    .MIN_TOTAL(MIN_TOTAL), .MAX_TOTAL(MAX_TOTAL), .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) u_cfg (
    .clk(clk), .rst(rst), .ring_en(ring_en), .en_rise(en_rise),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .start_wptr(wptr_hw), .base1(base1), .len1(len1), .base2(base2), .len2(len2),
    .start_ext(start_ext), .ext_active(ext_active), .cfg_fault(cfg_fault),
    .ring_len(ring_len)
  );

  srr_addr_map #(
    .AW(AW), .PW(PW), .LENW(LENW), .MAIN_BASE(MAIN_BASE),
    .MAIN_SLOTS(MAIN_SLOTS), .PKT(PKT)
  ) u_map (
    .ext(ext_active), .off(rptr), .base1(base1), .len1(len1),
    .base2(base2), .len2(len2), .addr(map_addr), .miss(map_miss)
  );

  srr_ptr_ctrl #(.AW(AW), .PW(PW), .TW(TW), .PKT(PKT)) u_ptr (
    .clk(clk), .rst(rst), .ring_en(ring_en), .en_rise(en_rise),
    .start_ext(start_ext), .ext_active(ext_active), .wptr_hw(wptr_hw),
    .legacy_wflag(legacy_wflag), .irq(irq), .zero_seen(zero_seen), .req(req),
    .ring_len(ring_len), .map_addr(map_addr), .map_miss(map_miss),
    .rptr(rptr), .rsp_valid(rsp_valid), .rsp_empty(rsp_empty),
    .rsp_addr(rsp_addr), .range_err(range_err)
  );

  a_r6_mode_changes_on_start: assert property (@(posedge clk) disable iff (rst)
    !$past(en_rise) |-> $stable(ext_active));
endmodule

// File: tb/tb_sample_ring_reader.sv
module tb_sample_ring_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ring_en = 1'b0, cfg_we = 1'b0, legacy_wflag = 1'b0;
  logic        irq = 1'b0, zero_seen = 1'b0, req = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [7:0]  wptr_hw = '0;
  logic        rsp_valid, rsp_empty, ext_active, cfg_fault, range_err;
  logic [15:0] rsp_addr;

  localparam logic [15:0] MAINB = 16'hF8A0;

  sample_ring_reader dut (
    .clk(clk), .rst(rst), .ring_en(ring_en), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .wptr_hw(wptr_hw), .legacy_wflag(legacy_wflag),
    .irq(irq), .zero_seen(zero_seen), .req(req), .rsp_valid(rsp_valid),
    .rsp_empty(rsp_empty), .rsp_addr(rsp_addr), .ext_active(ext_active),
    .cfg_fault(cfg_fault), .range_err(range_err)
  );

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    bit          empty;
    logic [15:0] addr;
    string       tag;
  } exp_t;

  exp_t  sb[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  logic [15:0] b1 = 16'hEC10, b2 = 16'hF000;
  int    l1 = 8, l2 = 4;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && (rsp_valid || rsp_empty)) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R11 unexpected response", {15'd0, rsp_valid, rsp_addr}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(cyc == e.due, {e.tag, " latency"}, cyc, e.due);
        chk(rsp_empty == e.empty, {e.tag, " kind"}, rsp_empty, e.empty);
        if (!e.empty) chk(rsp_addr == e.addr, {e.tag, " addr"}, rsp_addr, e.addr);
      end
    end
  end

  function automatic logic [15:0] xaddr(input int off);
    if (off < 8)       return MAINB + 16'(off);
    if (off < 8 + l1)  return b1 + 16'(off - 8);
    return b2 + 16'(off - 8 - l1);
  endfunction

  task automatic ask(input bit empty, input logic [15:0] addr, input int lat, input string tag);
    exp_t e;
    e.due = cyc + lat; e.empty = empty; e.addr = addr; e.tag = tag;
    sb.push_back(e);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    if (lat == 2) @(negedge clk);
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    cfg_addr = 3'(a); cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_irq();
    irq = 1'b1; @(negedge clk); irq = 1'b0;
  endtask

  task automatic pulse_zero();
    zero_seen = 1'b1; @(negedge clk); zero_seen = 1'b0;
  endtask

  task automatic turn_on();
    ring_en = 1'b1; @(negedge clk);
  endtask

  task automatic turn_off();
    ring_en = 1'b0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!rsp_valid && !rsp_empty, "R1 responses", {rsp_valid, rsp_empty}, 0);
    chk(!ext_active && !cfg_fault && !range_err, "R1 flags",
        {ext_active, cfg_fault, range_err}, 0);

    // R11 requests while off give nothing (monitor reports any response)
    req = 1'b1; @(negedge clk); req = 1'b0;
    repeat (3) @(negedge clk);

    wr(0, b1); wr(1, 16'(l1)); wr(2, b2); wr(3, 16'(l2)); wr(4, 16'h0001);
    wptr_hw = 8'd0;
    turn_on();
    chk(ext_active && !cfg_fault, "R6 valid setup accepted", {ext_active, cfg_fault}, 2'b10);

    // R5 empty after reload, then reload finds data
    ask(1'b1, '0, 2, "R5 empty");
    wptr_hw = 8'd19;
    ask(1'b0, xaddr(0), 2, "R5 reload then read");
    for (int o = 1; o <= 18; o++) ask(1'b0, xaddr(o), 1, (o < 8) ? "R2 main" : "R3 extra");
    ask(1'b1, '0, 2, "R5 caught up");
    wptr_hw = 8'd2;
    ask(1'b0, xaddr(19), 2, "R3 last slot of region two");
    ask(1'b0, xaddr(0), 1, "R4 wrap to zero");
    ask(1'b0, xaddr(1), 1, "R11 one-cycle read");
    ask(1'b1, '0, 2, "R5 empty after wrap");

    // R10 write while on is ignored
    wr(0, 16'h1234);
    turn_off();
    wptr_hw = 8'd8;
    turn_on();
    wptr_hw = 8'd9;
    ask(1'b0, 16'hEC10, 2, "R10 base1 kept");

    // R9 read pointer equal to length, then beyond regions
    turn_off();
    wptr_hw = 8'd20;
    turn_on();
    chk(ext_active && !cfg_fault, "R6 start pointer equal to length", {ext_active, cfg_fault}, 2'b10);
    wptr_hw = 8'd3;
    ask(1'b0, 16'h0000, 2, "R9 out-of-region address");
    chk(range_err == 1'b1, "R9 error raised", range_err, 1);
    ask(1'b0, xaddr(0), 1, "R4 wrap after error");
    pulse_zero();
    ask(1'b0, xaddr(1), 1, "R8 zero ignored in segmented mode");
    chk(range_err == 1'b1, "R9 error sticky", range_err, 1);

    // R6 boundaries
    turn_off();
    wr(0, 16'hEC00); wr(1, 16'd40); wr(2, 16'hFBFC); wr(3, 16'd16);
    wptr_hw = 8'd0;
    turn_on();
    chk(ext_active && !cfg_fault, "R6 length 64 and base limits pass", {ext_active, cfg_fault}, 2'b10);
    turn_off();
    wr(3, 16'd17);
    turn_on();
    chk(!ext_active && cfg_fault, "R6 length 65 rejected", {ext_active, cfg_fault}, 2'b01);
    turn_off();
    wr(1, 16'd8); wr(3, 16'd4); wr(0, 16'hEBFF);
    legacy_wflag = 1'b1;
    turn_on();
    chk(!ext_active && cfg_fault, "R6 base below range rejected", {ext_active, cfg_fault}, 2'b01);

    // R7 fallback halves
    pulse_irq();
    ask(1'b0, MAINB + 16'd4, 1, "R7 irq to upper half");
    ask(1'b0, MAINB + 16'd5, 1, "R7 upper half");
    ask(1'b0, MAINB + 16'd6, 1, "R7 upper half");
    ask(1'b0, MAINB + 16'd7, 1, "R7 upper half end");
    ask(1'b1, '0, 2, "R4 fallback wrap reaches producer");
    legacy_wflag = 1'b0;
    pulse_irq();
    ask(1'b0, MAINB, 1, "R7 irq to lower half");
    pulse_zero();
    ask(1'b1, '0, 2, "R8 zero sample ends burst");

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R11 all expected responses seen", sb.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule